// File: doc/BRIEF.md
# Write-Policy Selectable Two-Way Data Cache

This block is a small two-way set-associative data cache. It sits between a processor's load/store port, a line-fill read port toward memory, and a write buffer that accepts one word per cycle. Each access carries two region attribute bits. These bits decide whether the access is handled write-back, write-through, or bypasses the cache entirely. All addresses on every port are word addresses. A line holds eight 32-bit words, and the number of sets is a parameter.

Read misses allocate a line. The line is fetched as an eight-beat burst that starts at the requested word and wraps within the line. Writes never allocate. A write that hits updates the line and then follows the region's policy. A write that misses goes straight to the write buffer. Dirtiness is kept separately for the lower half (words 0-3) and the upper half (words 4-7) of each line. A dirty victim, or a line named by a clean command, is copied in one cycle into a single-line eviction buffer. That buffer then streams only the dirty halves to the write buffer as four-word bursts. The processor is stalled during a fill and whenever a store needs the write port while the eviction buffer is draining.

Top module: `wpCache`

## Requirements
- R1: While reset is active and in the first cycle after it, with no request pending, `cpuStall`, `memRdReq`, `wbValid` and `cleanAck` are low, and every line is invalid, so the first cached read misses.
- R2: The attribute bits decode as follows: `cpuAttrC`=1 with `cpuAttrB`=0 is write-through. `cpuAttrC`=1 with `cpuAttrB`=1 is write-back. `cpuAttrC`=0 is uncached.
- R3: A cached read miss raises `memRdReq` for exactly one cycle, with `memRdAddr` equal to the requested word address, and keeps `cpuStall` high. The eight returned beats fill the line in wrapping order starting from that word. The read then completes with the filled data.
- R4: An uncached read fetches from memory on every access and allocates nothing. An uncached write is passed to the write port as a single store (`wbBurst`=0).
- R5: A write-through write hit updates the line and, in the same cycle, presents one single store with the same word address and data on the write port.
- R6: A write-back write hit updates the line, marks its half dirty and produces no write-port traffic. A later read of that word returns the new data.
- R7: A cached write miss is sent to the write port as a single store and does not allocate, so a later read of that word misses.
- R8: When a read miss selects a victim with a dirty half, the victim is first copied to the eviction buffer. Only the dirty halves are then sent, the lower half before the upper half. Each half is four beats with `wbBurst`=1 and ascending word addresses starting at the half's base.
- R9: A clean command (`cleanReq` with `cleanIdx`, `cleanWay`) is acknowledged by `cleanAck` only in a cycle with no processor request and an idle eviction buffer. It writes back the dirty halves as in R8, clears their dirty bits and keeps the line valid. A clean of a line with no dirty half produces no traffic.
- R10: Each set has a one-bit round-robin pointer. The pointer starts at way 0, names the victim of the next fill in that set, and toggles after each fill.
- R11: A store that needs the write port is stalled for as long as the eviction buffer is draining. It is issued in the cycle after the last burst beat.
- R12: Every read returns the value most recently stored to that address. After all lines are cleaned, memory equals the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access request, held until accepted |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAttrC | input | 1 | Region cacheable attribute |
| cpuAttrB | input | 1 | Region bufferable attribute (write-back when cacheable) |
| cpuAddr | input | ADDR_W | Word address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid when `cpuStall` is low |
| cpuStall | output | 1 | Access not completed this cycle |
| cleanReq | input | 1 | Clean command request |
| cleanIdx | input | log2(SETS) | Set addressed by the clean |
| cleanWay | input | 1 | Way addressed by the clean |
| cleanAck | output | 1 | Clean command accepted this cycle |
| memRdReq | output | 1 | Start of an eight-beat line read |
| memRdAddr | output | ADDR_W | Critical word address of the line read |
| memRdValid | input | 1 | Read beat valid |
| memRdData | input | 32 | Read beat data |
| wbValid | output | 1 | Write-buffer word valid |
| wbAddr | output | ADDR_W | Write-buffer word address |
| wbData | output | 32 | Write-buffer word data |
| wbBurst | output | 1 | 1 = beat of a half-line write-back, 0 = single store |

## Verification
The hardest state to reach from the ports is a store that arrives while the eviction buffer is still draining. A dirty victim drains in parallel with the fill that displaced it, so it is always empty again before the stalled load finishes. The bench reaches this case by dirtying both halves of a line, issuing a clean, and placing an uncached store in the very next cycle. The expected stall is exactly eight cycles, followed by the single store. Further directed sequences steer three lines into one set to expose the round-robin victim order and the lower-half-only write-back. Seeded random traffic then checks every read against a shadow copy of all stores.

// File: rtl/wpCachePkg.sv
package wpCachePkg;
  localparam int LINE_WORDS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_RET
  } cacheState_t;

  typedef struct packed {
    logic       wrHit;
    logic       markDirty;
    logic       wbPass;
    logic       evLoad;
    logic       clnLoad;
    logic       fillWr;
    logic       fillDone;
    logic       capCrit;
    logic       selHeld;
    logic [2:0] fillIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/wpCacheCtrl.sv
module wpCacheCtrl
  import wpCachePkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cpuReq,
  input  logic         cpuWe,
  input  logic         cpuAttrC,
  input  logic         cpuAttrB,
  input  logic [2:0]   cpuWordIdx,
  input  logic         cleanReq,
  input  logic         hit,
  input  logic         victimDirty,
  input  logic         cleanDirty,
  input  logic         evBusy,
  input  logic         memRdValid,
  output ctrlStrobes_t st,
  output logic         cpuStall,
  output logic         memRdReq,
  output logic         cleanAck
);
  cacheState_t stateQ, stateD;
  logic [2:0]  cntQ, critQ;
  logic        bypassQ;

  always_comb begin
    st       = '0;
    cpuStall = 1'b0;
    memRdReq = 1'b0;
    cleanAck = 1'b0;
    stateD   = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          if (!cpuAttrC) begin
            if (cpuWe) begin
              if (evBusy) cpuStall = 1'b1;
              else        st.wbPass = 1'b1;
            end else begin
              cpuStall = 1'b1;
              memRdReq = 1'b1;
              stateD   = ST_FILL;
            end
          end else if (cpuWe) begin
            if (hit && cpuAttrB) begin
              st.wrHit     = 1'b1;
              st.markDirty = 1'b1;
            end else if (evBusy) begin
              cpuStall = 1'b1;
            end else begin
              st.wbPass = 1'b1;
              st.wrHit  = hit;
            end
          end else if (!hit) begin
            cpuStall = 1'b1;
            if (!(victimDirty && evBusy)) begin
              st.evLoad = victimDirty;
              memRdReq  = 1'b1;
              stateD    = ST_FILL;
            end
          end
        end else if (cleanReq && !evBusy) begin
          cleanAck   = 1'b1;
          st.clnLoad = cleanDirty;
        end
      end
      ST_FILL: begin
        cpuStall   = 1'b1;
        st.fillIdx = critQ + cntQ;
        if (memRdValid) begin
          st.fillWr  = !bypassQ;
          st.capCrit = (cntQ == 3'd0);
          if (cntQ == 3'd7) begin
            st.fillDone = !bypassQ;
            stateD      = bypassQ ? ST_RET : ST_IDLE;
          end
        end
      end
      ST_RET: begin
        st.selHeld = 1'b1;
        stateD     = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      critQ   <= '0;
      bypassQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (memRdReq) begin
        cntQ    <= '0;
        critQ   <= cpuWordIdx;
        bypassQ <= !cpuAttrC;
      end else if (stateQ == ST_FILL && memRdValid) begin
        cntQ <= cntQ + 3'd1;
      end
    end
  end
endmodule

// File: rtl/wpCacheData.sv
module wpCacheData
  import wpCachePkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter int SETS   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            st,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  input  logic [$clog2(SETS)-1:0] cleanIdx,
  input  logic                    cleanWay,
  input  logic [DATA_W-1:0]       memRdData,
  output logic                    hit,
  output logic                    victimDirty,
  output logic                    cleanDirty,
  output logic                    evBusy,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    wbValid,
  output logic [ADDR_W-1:0]       wbAddr,
  output logic [DATA_W-1:0]       wbData,
  output logic                    wbBurst
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [TAG_W-1:0]  tagArr  [2][SETS];
  logic [DATA_W-1:0] dataArr [2][SETS][LINE_WORDS];
  logic              validQ  [2][SETS];
  logic [1:0]        dirtyQ  [2][SETS];
  logic              rrQ     [SETS];

  logic [DATA_W-1:0] evDataQ [LINE_WORDS];
  logic [LINE_W-1:0] evLineQ;
  logic [1:0]        evMaskQ;
  logic              evFullQ;
  logic [2:0]        beatQ;
  logic [DATA_W-1:0] heldQ;

  logic [IDX_W-1:0] idx, srcIdx;
  logic [TAG_W-1:0] tag;
  logic [OFF_W-1:0] wIdx;
  logic [1:0]       hitVec;
  logic             hitWay, vicWay, srcWay;

  assign idx  = cpuAddr[OFF_W +: IDX_W];
  assign tag  = cpuAddr[ADDR_W-1 -: TAG_W];
  assign wIdx = cpuAddr[OFF_W-1:0];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hitVec[w] = validQ[w][idx] && (tagArr[w][idx] == tag);
  end

  assign hit         = |hitVec;
  assign hitWay      = hitVec[1];
  assign vicWay      = rrQ[idx];
  assign victimDirty = validQ[vicWay][idx] && (|dirtyQ[vicWay][idx]);
  assign cleanDirty  = validQ[cleanWay][cleanIdx] && (|dirtyQ[cleanWay][cleanIdx]);
  assign srcWay      = st.clnLoad ? cleanWay : vicWay;
  assign srcIdx      = st.clnLoad ? cleanIdx : idx;
  assign cpuRdata    = st.selHeld ? heldQ : dataArr[hitWay][idx][wIdx];

  assign evBusy  = evFullQ;
  assign wbValid = evFullQ | st.wbPass;
  assign wbBurst = evFullQ;
  assign wbAddr  = evFullQ ? {evLineQ, beatQ} : cpuAddr;
  assign wbData  = evFullQ ? evDataQ[beatQ] : cpuWdata;

  // Arrays without reset: data, tags, eviction data, held uncached word
  always_ff @(posedge clk) begin
    if (st.wrHit) dataArr[hitWay][idx][wIdx] <= cpuWdata;
    if (st.fillWr) dataArr[vicWay][idx][st.fillIdx] <= memRdData;
    if (st.fillDone) tagArr[vicWay][idx] <= tag;
    if (st.capCrit) heldQ <= memRdData;
    if (st.evLoad || st.clnLoad) begin
      for (int k = 0; k < LINE_WORDS; k++) evDataQ[k] <= dataArr[srcWay][srcIdx][k];
    end
  end

  // State with reset: valid, dirty halves, round-robin pointers, drain sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 2; w++) begin
        for (int s = 0; s < SETS; s++) begin
          validQ[w][s] <= 1'b0;
          dirtyQ[w][s] <= 2'b00;
        end
      end
      for (int s = 0; s < SETS; s++) rrQ[s] <= 1'b0;
      evFullQ <= 1'b0;
      evMaskQ <= 2'b00;
      evLineQ <= '0;
      beatQ   <= '0;
    end else begin
      if (st.wrHit && st.markDirty) dirtyQ[hitWay][idx][wIdx[OFF_W-1]] <= 1'b1;
      if (st.fillDone) begin
        validQ[vicWay][idx] <= 1'b1;
        dirtyQ[vicWay][idx] <= 2'b00;
        rrQ[idx]            <= ~rrQ[idx];
      end
      if (st.clnLoad) dirtyQ[cleanWay][cleanIdx] <= 2'b00;
      if (st.evLoad || st.clnLoad) begin
        evFullQ <= 1'b1;
        evMaskQ <= dirtyQ[srcWay][srcIdx];
        evLineQ <= {tagArr[srcWay][srcIdx], srcIdx};
        beatQ   <= dirtyQ[srcWay][srcIdx][0] ? 3'd0 : 3'd4;
      end else if (evFullQ) begin
        if (beatQ[1:0] == 2'd3) begin
          if (!beatQ[2] && evMaskQ[1]) beatQ <= 3'd4;
          else                         evFullQ <= 1'b0;
        end else begin
          beatQ <= beatQ + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/wpCache.sv
module wpCache
  import wpCachePkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int SETS   = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuAttrC,
  input  logic              cpuAttrB,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuStall,
  input  logic              cleanReq,
  input  logic [IDX_W-1:0]  cleanIdx,
  input  logic              cleanWay,
  output logic              cleanAck,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [31:0]       wbData,
  output logic              wbBurst
);
  ctrlStrobes_t st;
  logic hit, victimDirty, cleanDirty, evBusy;

  assign memRdAddr = cpuAddr;

  wpCacheCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .cpuAttrC   (cpuAttrC),
    .cpuAttrB   (cpuAttrB),
    .cpuWordIdx (cpuAddr[2:0]),
    .cleanReq   (cleanReq),
    .hit        (hit),
    .victimDirty(victimDirty),
    .cleanDirty (cleanDirty),
    .evBusy     (evBusy),
    .memRdValid (memRdValid),
    .st         (st),
    .cpuStall   (cpuStall),
    .memRdReq   (memRdReq),
    .cleanAck   (cleanAck)
  );

  wpCacheData #(.ADDR_W(ADDR_W), .DATA_W(32), .SETS(SETS)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cleanIdx   (cleanIdx),
    .cleanWay   (cleanWay),
    .memRdData  (memRdData),
    .hit        (hit),
    .victimDirty(victimDirty),
    .cleanDirty (cleanDirty),
    .evBusy     (evBusy),
    .cpuRdata   (cpuRdata),
    .wbValid    (wbValid),
    .wbAddr     (wbAddr),
    .wbData     (wbData),
    .wbBurst    (wbBurst)
  );
endmodule

// File: rtl/wpCacheChk.sv
module wpCacheChk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuAttrC,
  input logic              cpuStall,
  input logic              cleanAck,
  input logic              memRdReq,
  input logic              wbValid,
  input logic [ADDR_W-1:0] wbAddr,
  input logic              wbBurst
);
  p_rdreq_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |-> cpuStall);

  p_rdreq_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq |=> !memRdReq);

  p_single_store_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbBurst) |-> (cpuReq && cpuWe && !cpuStall));

  p_burst_ascend_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbBurst && wbAddr[1:0] != 2'd0) |->
      ($past(wbValid && wbBurst) && wbAddr == $past(wbAddr) + 1'b1));

  p_clean_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    cleanAck |-> (!cpuReq && !wbBurst));

  p_drain_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbBurst && cpuReq && cpuWe && !cpuAttrC) |-> cpuStall);

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!wbValid || !wbBurst);
    end
  end
endmodule

bind wpCache wpCacheChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuAttrC(cpuAttrC),
  .cpuStall(cpuStall),
  .cleanAck(cleanAck),
  .memRdReq(memRdReq),
  .wbValid (wbValid),
  .wbAddr  (wbAddr),
  .wbBurst (wbBurst)
);

// File: tb/tb_wpCache.sv
module tb_wpCache;
  localparam int ADDR_W = 30;
  localparam int SETS   = 4;

  logic clk = 1'b0;
  logic rstN;
  logic cpuReq, cpuWe, cpuAttrC, cpuAttrB;
  logic [ADDR_W-1:0] cpuAddr;
  logic [31:0] cpuWdata, cpuRdata;
  logic cpuStall;
  logic cleanReq, cleanWay, cleanAck;
  logic [1:0] cleanIdx;
  logic memRdReq, memRdValid;
  logic [ADDR_W-1:0] memRdAddr;
  logic [31:0] memRdData;
  logic wbValid, wbBurst;
  logic [ADDR_W-1:0] wbAddr;
  logic [31:0] wbData;

  always #10 clk = ~clk;

  wpCache #(.ADDR_W(ADDR_W), .SETS(SETS)) dut (.*);

  logic [31:0] mem    [256];
  logic [31:0] shadow [256];
  int errors = 0, checks = 0;
  int rdReqCnt = 0;
  logic [ADDR_W-1:0] lastRdAddr;
  int wbCnt = 0;
  logic [ADDR_W-1:0] logAddr [4096];
  logic [31:0]       logData [4096];
  logic              logBurst[4096];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory line-read responder: two-cycle latency, eight wrapping beats
  initial begin
    memRdValid = 1'b0;
    memRdData  = '0;
    forever begin
      @(posedge clk);
      if (rstN && memRdReq) begin
        automatic logic [7:0] base = memRdAddr[7:0];
        rdReqCnt++;
        lastRdAddr = memRdAddr;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          memRdValid = 1'b1;
          memRdData  = mem[{base[7:3], base[2:0] + k[2:0]}];
          @(negedge clk);
        end
        memRdValid = 1'b0;
      end
    end
  end

  // write-buffer sink
  always @(posedge clk) begin
    if (rstN && wbValid) begin
      mem[wbAddr[7:0]] = wbData;
      if (wbCnt < 4096) begin
        logAddr[wbCnt]  = wbAddr;
        logData[wbCnt]  = wbData;
        logBurst[wbCnt] = wbBurst;
      end
      wbCnt++;
    end
  end

  // region map: word[7:6] 0,1 write-back; 2 write-through; 3 uncached
  task automatic access(input logic we, input int w, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
    logic [7:0] w8;
    w8 = w[7:0];
    @(negedge clk);
    cpuReq   = 1'b1;
    cpuWe    = we;
    cpuAddr  = ADDR_W'(w8);
    cpuWdata = d;
    cpuAttrC = (w8[7:6] != 2'd3);
    cpuAttrB = (w8[7:6] <= 2'd1);
    stalls   = 0;
    #1;
    while (cpuStall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd = cpuRdata;
    @(posedge clk);
    #2;
    cpuReq = 1'b0;
    cpuWe  = 1'b0;
    if (we) shadow[w8] = d;
  endtask

  task automatic clean(input int s, input logic way);
    @(negedge clk);
    cleanReq = 1'b1;
    cleanIdx = s[1:0];
    cleanWay = way;
    #1;
    while (!cleanAck) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #2;
    cleanReq = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, rc, wc, bad;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 32'hC0DE_0000 ^ (i * 32'h0001_0203);
      shadow[i] = mem[i];
    end
    rstN = 1'b0; cpuReq = 0; cpuWe = 0; cpuAttrC = 0; cpuAttrB = 0;
    cpuAddr = '0; cpuWdata = '0; cleanReq = 0; cleanIdx = 0; cleanWay = 0;
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check(!cpuStall && !memRdReq && !wbValid && !cleanAck, "R1 idle outputs after reset",
          {28'd0, cpuStall, memRdReq, wbValid, cleanAck}, 32'd0);

    // R3 read miss with critical word, wrap fill; R1 first access misses
    rc = rdReqCnt;
    access(0, 5, 0, rd, st);
    check(rdReqCnt == rc + 1, "R1 first read misses", rdReqCnt - rc, 1);
    check(lastRdAddr == 5, "R3 critical word address", lastRdAddr, 5);
    check(rd == shadow[5], "R3 miss data", rd, shadow[5]);
    check(st > 0, "R3 miss stalls", st, 1);
    // R2 hit on wrapped word, no stall, no memory read
    rc = rdReqCnt;
    access(0, 2, 0, rd, st);
    check(rd == shadow[2] && st == 0 && rdReqCnt == rc, "R2 read hit", rd, shadow[2]);
    // R6 write-back hit: no traffic
    wc = wbCnt;
    access(1, 6, 32'hAAAA_0006, rd, st);
    repeat (3) @(negedge clk);
    check(wbCnt == wc, "R6 write-back hit silent", wbCnt - wc, 0);
    access(0, 6, 0, rd, st);
    check(rd == 32'hAAAA_0006, "R6 read back", rd, 32'hAAAA_0006);
    // R9 clean: upper half only, line stays valid
    wc = wbCnt;
    clean(0, 1'b0);
    repeat (10) @(negedge clk);
    check(wbCnt == wc + 4, "R9 clean beat count", wbCnt - wc, 4);
    for (int k = 0; k < 4; k++)
      check(logAddr[wc+k] == ADDR_W'(4 + k) && logBurst[wc+k] && logData[wc+k] == shadow[4+k],
            "R9 clean half burst", logAddr[wc+k], 4 + k);
    rc = rdReqCnt;
    access(0, 5, 0, rd, st);
    check(rdReqCnt == rc && rd == shadow[5], "R9 line stays valid", rdReqCnt - rc, 0);
    wc = wbCnt;
    clean(0, 1'b0);
    repeat (10) @(negedge clk);
    check(wbCnt == wc, "R9 clean of clean line silent", wbCnt - wc, 0);
    // R5 write-through hit
    access(0, 129, 0, rd, st);
    wc = wbCnt;
    access(1, 129, 32'h5555_0081, rd, st);
    check(wbCnt == wc + 1 && !logBurst[wc] && logAddr[wc] == 129 && logData[wc] == 32'h5555_0081,
          "R5 write-through store", logData[wc], 32'h5555_0081);
    rc = rdReqCnt;
    access(0, 129, 0, rd, st);
    check(rd == 32'h5555_0081 && rdReqCnt == rc, "R5 line updated", rd, 32'h5555_0081);
    // R7 write miss: no allocate
    wc = wbCnt;
    access(1, 40, 32'h7777_0028, rd, st);
    check(wbCnt == wc + 1 && !logBurst[wc] && logAddr[wc] == 40, "R7 miss store passed", logAddr[wc], 40);
    rc = rdReqCnt;
    access(0, 40, 0, rd, st);
    check(rdReqCnt == rc + 1 && rd == 32'h7777_0028, "R7 no allocation", rdReqCnt - rc, 1);
    // R4 uncached bypass
    rc = rdReqCnt;
    access(0, 200, 0, rd, st);
    access(0, 200, 0, rd, st);
    check(rdReqCnt == rc + 2 && rd == shadow[200], "R4 uncached read each time", rdReqCnt - rc, 2);
    wc = wbCnt;
    access(1, 201, 32'h0000_00C9, rd, st);
    check(wbCnt == wc + 1 && !logBurst[wc] && logAddr[wc] == 201, "R4 uncached store", logAddr[wc], 201);
    // R8/R10 dirty victim, lower half only, round robin
    access(1, 1, 32'hBEEF_0001, rd, st);
    wc = wbCnt;
    access(0, 32, 0, rd, st);
    check(wbCnt == wc + 4, "R8 victim lower half only", wbCnt - wc, 4);
    for (int k = 0; k < 4; k++)
      check(logAddr[wc+k] == ADDR_W'(k) && logBurst[wc+k] && logData[wc+k] == shadow[k],
            "R8 victim burst beat", logAddr[wc+k], k);
    rc = rdReqCnt;
    access(0, 129, 0, rd, st);
    check(rdReqCnt == rc, "R10 other way kept", rdReqCnt - rc, 0);
    access(0, 1, 0, rd, st);
    check(rdReqCnt == rc + 1 && rd == 32'hBEEF_0001, "R10 way 0 was victim", rd, 32'hBEEF_0001);
    // R11 store during drain, both halves lower first
    access(1, 41, 32'h1111_0029, rd, st);
    access(1, 45, 32'h2222_002D, rd, st);
    wc = wbCnt;
    clean(1, 1'b0);
    access(1, 210, 32'h3333_00D2, rd, st);
    check(st == 8, "R11 store stalled through drain", st, 8);
    check(wbCnt == wc + 9 && !logBurst[wc+8] && logAddr[wc+8] == 210, "R11 store after drain",
          logAddr[wc+8], 210);
    for (int k = 0; k < 8; k++)
      check(logAddr[wc+k] == ADDR_W'(40 + k) && logBurst[wc+k], "R8 both halves lower first",
            logAddr[wc+k], 40 + k);

    // R12 random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      automatic int w = int'($urandom % 256);
      automatic logic we = ($urandom % 3) == 0;
      if (($urandom % 16) == 0) clean(int'($urandom % 4), 1'($urandom % 2));
      access(we, w, $urandom, rd, st);
      if (!we) check(rd == shadow[w], "R12 random read", rd, shadow[w]);
    end
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) clean(s, 1'(w));
    repeat (12) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) bad++;
    check(bad == 0, "R12 memory matches after clean", bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule